// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit decides whether a load or store may go ahead by comparing the tag carried in the top byte of its 64-bit pointer with the tag stored for the 16-byte granule it touches. A request arrives with the tagged address, a size code and a load/store flag over a valid/ready handshake. The unit fetches the granule's tag byte through a shadow read port and compares it with the pointer tag. When the shadow byte is a small value (1 to 15), it is taken as the number of valid bytes in a partly used granule. In that case the access must fall inside those bytes, and the real tag is then fetched from the granule's final byte through a second, data-byte read port.

Each check produces a one-cycle result with a fault flag, an allow flag and a syndrome: the load/store flag, the size code and the full tagged address. In recover mode a fault is still flagged, but the access is allowed, so the fault acts as a warning. The unit works on one check at a time. It accepts no new request until the result of the current one has been issued.

Top module: `tag_check_unit`

## Requirements
- R1: After reset `reqReady` is 1 and `resValid`, `shRdValid` and `dbRdValid` are 0.
- R2: Every check with a legal size issues exactly one shadow read, at address `SHADOW_BASE + addr[55:4]`.
- R3: If the shadow byte equals the pointer tag `addr[63:56]`, the result is a pass and no data-byte read is made.
- R4: If the tags differ and the shadow byte is 0 or 16 or more, the result is a fault and no data-byte read is made.
- R5: If the tags differ and the shadow byte S is between 1 and 15, let P = `addr[3:0]` + 2^size − 1. If P ≥ S, the result is a fault and no data-byte read is made.
- R6: If the tags differ, S is between 1 and 15 and P < S, one data-byte read is made at `{8'h00, addr[55:4], 4'hF}`. The check passes only if the returned byte equals the pointer tag.
- R7: Pointer tags from 1 to 15 are treated like any other tag. They pass through either the fast path or the data-byte path whenever the comparisons allow it.
- R8: Size codes 0 to 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 give a fault with no shadow or data-byte read.
- R9: `resValid` is high for exactly one cycle per check. At that cycle `synIsStore`, `synSizeCode` and `synAddr` hold the request's flag, size code and full 64-bit address.
- R10: `resAllow` is 1 when `resFault` is 0, and equals `recoverMode` when `resFault` is 1.
- R11: `reqReady` is 0 from the cycle after a request is accepted through the cycle that carries its result, and is 1 again in the following cycle.
- R12: A read request (`shRdValid` or `dbRdValid`) stays asserted, with a stable address, until its ready is seen. Each response is taken on its valid at any latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| recoverMode | input | 1 | When 1, a fault is reported but the access is allowed |
| reqValid | input | 1 | Check request valid |
| reqReady | output | 1 | Unit idle and able to accept a request |
| reqAddr | input | 64 | Tagged address, pointer tag in bits 63:56 |
| reqSize | input | 3 | Access size as log2 of the byte count |
| reqIsStore | input | 1 | 1 for a store, 0 for a load |
| shRdValid | output | 1 | Shadow read request |
| shRdReady | input | 1 | Shadow port accepts the request |
| shRdAddr | output | 64 | Shadow byte address |
| shRspValid | input | 1 | Shadow response valid |
| shRspData | input | 8 | Shadow byte |
| dbRdValid | output | 1 | Data-byte read request |
| dbRdReady | input | 1 | Data-byte port accepts the request |
| dbRdAddr | output | 64 | Address of the granule's last byte |
| dbRspValid | input | 1 | Data-byte response valid |
| dbRspData | input | 8 | Last byte of the granule |
| resValid | output | 1 | One-cycle result strobe |
| resFault | output | 1 | Tag check failed |
| resAllow | output | 1 | Access may proceed |
| synIsStore | output | 1 | Syndrome: load/store flag |
| synSizeCode | output | 3 | Syndrome: size code |
| synAddr | output | 64 | Syndrome: full tagged address |

## Verification
The hardest case to reach is the second read on a partly used granule. It needs a tag mismatch, a shadow value between 1 and 15, and an offset plus size that lands just inside or just outside the valid length. The returned last byte must also match or miss the pointer tag. The bench reaches it with a nested sweep over shadow values 0 to 17, every granule offset and every size code, with a rotating choice of pointer tag and last byte. This puts every bound on both sides. The port latencies are varied from check to check, so that held requests and late responses occur as well.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SH_REQ,
    ST_SH_WAIT,
    ST_DB_REQ,
    ST_DB_WAIT,
    ST_DONE
  } tcuState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadShadow;
    logic markPass;
    logic markFault;
  } tcuStrobes_t;

  // decisions from datapath to control
  typedef struct packed {
    logic sizeBad;
    logic tagHit;
    logic shortFits;
    logic lastHit;
  } tcuStatus_t;

endpackage

// File: rtl/tcu_datapath.sv
module tcu_datapath
  import tcu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TAG_W = 8,
  parameter int GRAN_LOG2 = 4,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcuStrobes_t       strb,
  output tcuStatus_t        stat,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqIsStore,
  input  logic [TAG_W-1:0]  shRspData,
  input  logic [TAG_W-1:0]  dbRspData,
  output logic [ADDR_W-1:0] shRdAddr,
  output logic [ADDR_W-1:0] dbRdAddr,
  output logic [TAG_W-1:0]  shadowSeen,
  output logic              faultOut,
  output logic              synIsStore,
  output logic [SIZE_W-1:0] synSizeCode,
  output logic [ADDR_W-1:0] synAddr
);

  localparam int TAG_LSB = ADDR_W - TAG_W;
  localparam int GRAN_BYTES = 1 << GRAN_LOG2;
  localparam int POS_W = GRAN_LOG2 + 1;
  localparam int MAX_SIZE_CODE = GRAN_LOG2;

  logic [ADDR_W-1:0] addrReg;
  logic [SIZE_W-1:0] sizeReg;
  logic              storeReg;
  logic [TAG_W-1:0]  shadowReg;
  logic              faultReg;

  logic [TAG_W-1:0]  ptrTag;
  logic [POS_W-1:0]  posLast;
  logic              shortRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      sizeReg   <= '0;
      storeReg  <= 1'b0;
      shadowReg <= '0;
      faultReg  <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        addrReg  <= reqAddr;
        sizeReg  <= reqSize;
        storeReg <= reqIsStore;
      end
      if (strb.loadShadow) shadowReg <= shRspData;
      if (strb.markFault) faultReg <= 1'b1;
      else if (strb.markPass || strb.loadReq) faultReg <= 1'b0;
    end
  end

  assign ptrTag = addrReg[ADDR_W-1:TAG_LSB];

  // position of the last byte touched inside the granule
  assign posLast = POS_W'(addrReg[GRAN_LOG2-1:0])
                 + (POS_W'(1) << sizeReg) - POS_W'(1);

  assign shortRange = (shRspData != '0) && (shRspData < TAG_W'(GRAN_BYTES));

  assign stat.sizeBad   = (reqSize > SIZE_W'(MAX_SIZE_CODE));
  assign stat.tagHit    = (shRspData == ptrTag);
  assign stat.shortFits = shortRange && (TAG_W'(posLast) < shRspData);
  assign stat.lastHit   = (dbRspData == ptrTag);

  assign shRdAddr = SHADOW_BASE + ADDR_W'(addrReg[TAG_LSB-1:GRAN_LOG2]);
  assign dbRdAddr = {{TAG_W{1'b0}}, addrReg[TAG_LSB-1:GRAN_LOG2], {GRAN_LOG2{1'b1}}};

  assign shadowSeen  = shadowReg;
  assign faultOut    = faultReg;
  assign synIsStore  = storeReg;
  assign synSizeCode = sizeReg;
  assign synAddr     = addrReg;

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.markPass && strb.markFault));

  p_fault_sticks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.markFault) |=> faultReg);

endmodule

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
  import tcu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  tcuStatus_t  stat,
  output tcuStrobes_t strb,
  output logic        shRdValid,
  input  logic        shRdReady,
  input  logic        shRspValid,
  output logic        dbRdValid,
  input  logic        dbRdReady,
  input  logic        dbRspValid,
  output logic        resValid
);

  tcuState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.loadReq = 1'b1;
          if (stat.sizeBad) begin
            strb.markFault = 1'b1;
            stateNext      = ST_DONE;
          end else begin
            stateNext = ST_SH_REQ;
          end
        end
      end
      ST_SH_REQ: if (shRdReady) stateNext = ST_SH_WAIT;
      ST_SH_WAIT: begin
        if (shRspValid) begin
          strb.loadShadow = 1'b1;
          if (stat.tagHit) begin
            strb.markPass = 1'b1;
            stateNext     = ST_DONE;
          end else if (stat.shortFits) begin
            stateNext = ST_DB_REQ;
          end else begin
            strb.markFault = 1'b1;
            stateNext      = ST_DONE;
          end
        end
      end
      ST_DB_REQ: if (dbRdReady) stateNext = ST_DB_WAIT;
      ST_DB_WAIT: begin
        if (dbRspValid) begin
          if (stat.lastHit) strb.markPass = 1'b1;
          else              strb.markFault = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady  = (state == ST_IDLE);
  assign shRdValid = (state == ST_SH_REQ);
  assign dbRdValid = (state == ST_DB_REQ);
  assign resValid  = (state == ST_DONE);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_sh_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (shRdValid && !shRdReady) |=> shRdValid);

  p_db_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (dbRdValid && !dbRdReady) |=> dbRdValid);

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(shRdValid && dbRdValid));

endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tcu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TAG_W = 8,
  parameter int GRAN_LOG2 = 4,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 64'h0000_1000_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recoverMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqIsStore,
  output logic              shRdValid,
  input  logic              shRdReady,
  output logic [ADDR_W-1:0] shRdAddr,
  input  logic              shRspValid,
  input  logic [TAG_W-1:0]  shRspData,
  output logic              dbRdValid,
  input  logic              dbRdReady,
  output logic [ADDR_W-1:0] dbRdAddr,
  input  logic              dbRspValid,
  input  logic [TAG_W-1:0]  dbRspData,
  output logic              resValid,
  output logic              resFault,
  output logic              resAllow,
  output logic              synIsStore,
  output logic [SIZE_W-1:0] synSizeCode,
  output logic [ADDR_W-1:0] synAddr
);

  localparam int GRAN_BYTES = 1 << GRAN_LOG2;

  tcuStrobes_t strb;
  tcuStatus_t  stat;
  logic [TAG_W-1:0] shadowSeen;
  logic faultOut;

  tcu_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .stat       (stat),
    .strb       (strb),
    .shRdValid  (shRdValid),
    .shRdReady  (shRdReady),
    .shRspValid (shRspValid),
    .dbRdValid  (dbRdValid),
    .dbRdReady  (dbRdReady),
    .dbRspValid (dbRspValid),
    .resValid   (resValid)
  );

  tcu_datapath #(
    .ADDR_W      (ADDR_W),
    .TAG_W       (TAG_W),
    .GRAN_LOG2   (GRAN_LOG2),
    .SIZE_W      (SIZE_W),
    .SHADOW_BASE (SHADOW_BASE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stat        (stat),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .reqIsStore  (reqIsStore),
    .shRspData   (shRspData),
    .dbRspData   (dbRspData),
    .shRdAddr    (shRdAddr),
    .dbRdAddr    (dbRdAddr),
    .shadowSeen  (shadowSeen),
    .faultOut    (faultOut),
    .synIsStore  (synIsStore),
    .synSizeCode (synSizeCode),
    .synAddr     (synAddr)
  );

  assign resFault = faultOut;
  assign resAllow = !faultOut || recoverMode;

  p_db_short_r6: assert property (@(posedge clk) disable iff (!rstN)
    dbRdValid |-> (shadowSeen != '0 && shadowSeen < TAG_W'(GRAN_BYTES)));

  p_sh_addr_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (shRdValid && !shRdReady) |=> $stable(shRdAddr));

  p_db_addr_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (dbRdValid && !dbRdReady) |=> $stable(dbRdAddr));

  p_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resAllow) |-> (resFault && !recoverMode));

endmodule

// File: tb/tag_check_unit_tb_top.sv
module tag_check_unit_tb_top;

  localparam logic [63:0] TB_BASE = 64'h0000_2000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic recoverMode = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [63:0] reqAddr = '0;
  logic [2:0] reqSize = '0;
  logic reqIsStore = 1'b0;
  logic shRdValid;
  logic shRdReady = 1'b0;
  logic [63:0] shRdAddr;
  logic shRspValid = 1'b0;
  logic [7:0] shRspData = '0;
  logic dbRdValid;
  logic dbRdReady = 1'b0;
  logic [63:0] dbRdAddr;
  logic dbRspValid = 1'b0;
  logic [7:0] dbRspData = '0;
  logic resValid, resFault, resAllow, synIsStore;
  logic [2:0] synSizeCode;
  logic [63:0] synAddr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  tag_check_unit #(.SHADOW_BASE(TB_BASE)) dut_i (
    .clk(clk), .rstN(rstN), .recoverMode(recoverMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqIsStore(reqIsStore),
    .shRdValid(shRdValid), .shRdReady(shRdReady), .shRdAddr(shRdAddr),
    .shRspValid(shRspValid), .shRspData(shRspData),
    .dbRdValid(dbRdValid), .dbRdReady(dbRdReady), .dbRdAddr(dbRdAddr),
    .dbRspValid(dbRspValid), .dbRspData(dbRspData),
    .resValid(resValid), .resFault(resFault), .resAllow(resAllow),
    .synIsStore(synIsStore), .synSizeCode(synSizeCode), .synAddr(synAddr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic runOne(input logic [7:0] tag, input logic [51:0] gIdx,
                        input logic [3:0] off, input logic [2:0] sz,
                        input bit st, input bit rec, input logic [7:0] shVal,
                        input logic [7:0] lastByte, input int lat,
                        input string forceReq);
    logic [63:0] addr;
    bit expFault, expDb, expSh;
    string rq;
    int pos, cyc, shCnt, dbCnt, nSh, nDb;
    bit shPend, dbPend, done, busyBad;
    logic [63:0] shAddrSeen, dbAddrSeen, gotAddr;
    logic gotFault, gotAllow, gotSt;
    logic [2:0] gotSz;

    addr = {tag, gIdx, off};
    expSh = 1'b1; expDb = 1'b0;
    if (sz > 3'd4) begin
      expFault = 1'b1; expSh = 1'b0; rq = "R8";
    end else if (tag == shVal) begin
      expFault = 1'b0; rq = "R3";
    end else if (shVal == 8'd0 || shVal >= 8'd16) begin
      expFault = 1'b1; rq = "R4";
    end else begin
      pos = int'(off) + (1 << sz) - 1;
      if (pos >= int'(shVal)) begin
        expFault = 1'b1; rq = "R5";
      end else begin
        expDb = 1'b1; expFault = (lastByte != tag); rq = "R6";
      end
    end
    if (forceReq != "") rq = forceReq;

    cyc = 0; shCnt = 0; dbCnt = 0; nSh = 0; nDb = 0;
    shPend = 0; dbPend = 0; done = 0; busyBad = 0;
    shAddrSeen = '0; dbAddrSeen = '0; gotAddr = '0;
    gotFault = 0; gotAllow = 0; gotSt = 0; gotSz = '0;

    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = sz; reqIsStore = st;
    recoverMode = rec;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      reqValid = 1'b0;
      if (resValid) begin
        done = 1; gotFault = resFault; gotAllow = resAllow;
        gotAddr = synAddr; gotSt = synIsStore; gotSz = synSizeCode;
      end else if (reqReady) begin
        busyBad = 1;
      end
      shRspValid = 1'b0;
      if (shPend) begin shRspValid = 1'b1; shRspData = shVal; shPend = 0; end
      if (shRdValid) begin
        if (shCnt >= lat) begin
          shRdReady = 1'b1; nSh++; shAddrSeen = shRdAddr; shPend = 1;
        end else begin
          shRdReady = 1'b0; shCnt++;
        end
      end else shRdReady = 1'b0;
      dbRspValid = 1'b0;
      if (dbPend) begin dbRspValid = 1'b1; dbRspData = lastByte; dbPend = 0; end
      if (dbRdValid) begin
        if (dbCnt >= lat) begin
          dbRdReady = 1'b1; nDb++; dbAddrSeen = dbRdAddr; dbPend = 1;
        end else begin
          dbRdReady = 1'b0; dbCnt++;
        end
      end else dbRdReady = 1'b0;
    end

    chk(done, "R11", "result timeout", 64'(done), 64'd1);
    chk(gotFault == expFault, rq, "fault", 64'(gotFault), 64'(expFault));
    chk(gotAllow == (!expFault || rec), "R10", "allow", 64'(gotAllow),
        64'(!expFault || rec));
    chk(gotAddr == addr, "R9", "syndrome addr", gotAddr, addr);
    chk(gotSz == sz && gotSt == st, "R9", "syndrome size/store",
        {60'd0, gotSz, gotSt}, {60'd0, sz, st});
    chk(nSh == int'(expSh), "R2", "shadow reads R12", 64'(nSh), 64'(expSh));
    if (expSh)
      chk(shAddrSeen == TB_BASE + 64'(gIdx), "R2", "shadow addr", shAddrSeen,
          TB_BASE + 64'(gIdx));
    chk(nDb == int'(expDb), rq, "data-byte reads", 64'(nDb), 64'(expDb));
    if (expDb)
      chk(dbAddrSeen == {8'h00, gIdx, 4'hF}, "R6", "data-byte addr",
          dbAddrSeen, {8'h00, gIdx, 4'hF});
    chk(!busyBad, "R11", "ready while busy", 64'(busyBad), 64'd0);
    @(negedge clk);
    chk(!resValid && reqReady, "R9", "pulse end / ready back R11",
        {62'd0, resValid, reqReady}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] tg;
    logic [7:0] lb;
    int k;
    repeat (3) @(negedge clk);
    chk(reqReady && !resValid && !shRdValid && !dbRdValid, "R1", "reset outputs",
        {60'd0, reqReady, resValid, shRdValid, dbRdValid}, 64'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !resValid && !shRdValid && !dbRdValid, "R1", "after reset",
        {60'd0, reqReady, resValid, shRdValid, dbRdValid}, 64'h8);

    for (int sv = 0; sv < 18; sv++) begin
      for (int of = 0; of < 16; of++) begin
        for (int sz = 0; sz < 8; sz++) begin
          k = (sv * 7 + of + sz) % 4;
          case (k)
            0: tg = 8'(sv);
            1: tg = 8'hA5;
            2: tg = 8'((of % 15) + 1);
            default: tg = 8'h3C;
          endcase
          lb = (of % 2 == 1) ? tg : (tg ^ 8'h40);
          runOne(tg, 52'h0_00AB_CDEF_0120 + 52'(sv * 64 + of * 4 + sz),
                 4'(of), 3'(sz), sz[0], (sv % 2) != (of % 2), 8'(sv), lb,
                 (of + sz) % 4, "");
        end
      end
    end

    // R7: small pointer tags through both the fast path and the last-byte path
    for (int t = 1; t < 16; t++) begin
      runOne(8'(t), 52'h0_0000_0000_7700 + 52'(t), 4'd0, 3'd0, 1'b0, 1'b0,
             8'd15, 8'(t), t % 3, "R7");
      runOne(8'(t), 52'h0_0000_0000_7800 + 52'(t), 4'd3, 3'd2, 1'b1, 1'b0,
             8'(t), 8'h00, 2, "R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule